// File: doc/BRIEF.md
# Six-Line Vectored Priority Interrupt Controller

The controller collects interrupt requests from six peripheral lines, numbered IRQ2 to IRQ7. It tells the processor through a single request output when a request should be serviced. When the processor acknowledges, the controller answers with an 8-bit type byte that the processor uses to find its service routine.

A rising edge on a line records a request. The request stays recorded until the processor acknowledges it. An 8-bit mask byte, readable and writable, decides which lines may interrupt the processor. Priority is fixed, and the lowest line number wins. Each acknowledged level stays marked as in service until the service routine issues an end-of-interrupt strobe. While a level is in service, it blocks itself and every level of lower priority. Levels of higher priority can still nest on top of it.

Top module: `vec_pic`

## Requirements
- R1: Reset sets the following values. `mask_rdata` reads 0xFF, so every line is masked. `intr` is low. `vec_valid` is low. No request is pending and no level is in service.
- R2: A cycle with `mask_wr` high loads all 8 bits of `mask_wdata` into the mask byte, and `mask_rdata` returns that byte from the next cycle on. Bit n of the byte belongs to IRQn, with n from 2 to 7. A 1 blocks the line and a 0 enables it. Bits 0 and 1 are stored but gate nothing.
- R3: A request on a masked line is still recorded, but it cannot raise `intr`. Clearing its mask bit raises `intr` in the cycle after the write.
- R4: Requests are recorded only on a 0-to-1 transition of a line. Bit i of `irq_lines` is IRQ(i+2). A line that stays high after its request was acknowledged makes no new request. The line must fall and rise again to make one.
- R5: `intr` goes high in the cycle right after the clock edge that first samples the line high. No other register lies in the path.
- R6: Among pending, unmasked requests, the lowest IRQ number wins.
- R7: `inta` high at a clock edge while `intr` is high acknowledges the winning request. In the next cycle `vec_valid` is high for one cycle and `vec_data` holds the winner's IRQ number plus 8. The winner's request is cleared and its level is marked in service.
- R8: While a level is in service, pending requests of the same or a higher IRQ number do not raise `intr`. A request of a lower IRQ number does raise it.
- R9: An `eoi` strobe clears only the in-service level of highest priority, that is, the lowest number. Pending requests it was blocking may then raise `intr`.
- R10: `inta` with `intr` low is a spurious acknowledge. It returns type 15 with `vec_valid` high and leaves the in-service levels unchanged.
- R11: A new rising edge on a line whose level is in service is held pending. It raises `intr` once that level is cleared by `eoi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 6 | Request lines. Bit i is IRQ(i+2) |
| mask_wr | input | 1 | Write strobe for the mask byte |
| mask_wdata | input | 8 | Mask byte to write. Bit n is IRQn, and 1 blocks the line |
| mask_rdata | output | 8 | Current mask byte |
| inta | input | 1 | Processor acknowledge, one cycle per acknowledge |
| eoi | input | 1 | End-of-interrupt strobe, one cycle |
| intr | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Type byte is valid, high for one cycle after `inta` |
| vec_data | output | 8 | Interrupt type byte |

## Verification
A vector table applies several request patterns to the lines at once, under different mask bytes. Single lines at each end of the range show that the type byte is computed correctly for each line. Mixed patterns under partial masks show whether the priority choice looks at pending requests only or at pending requests filtered by the mask. Directed nesting sequences show the difference between three cases: a request of equal priority, one of lower priority, and one of higher priority, each arriving while a level is in service. Two further sequences show the difference between a line held at a level and a line that produces a new edge, and between a real acknowledge and a spurious one.

// File: rtl/vec_pic_pkg.sv
`timescale 1ns/1ps
package vec_pic_pkg;
    // Default geometry of the controller
    localparam int unsigned PIC_NUM_IRQ   = 6;
    localparam int unsigned PIC_FIRST_IRQ = 2;
    localparam int unsigned PIC_VEC_BASE  = 8;
    localparam int unsigned PIC_DATA_W    = 8;

    // Width of an index into n lines, never below one bit
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/vec_pic_prio_find.sv
`timescale 1ns/1ps
// Finds the lowest set bit of a vector: fixed priority, index 0 highest
module vec_pic_prio_find
    import vec_pic_pkg::*;
#(
    parameter int unsigned W = 6
) (
    input  logic [W-1:0]              vec,
    output logic                      found,
    output logic [idx_width(W)-1:0]   idx,
    output logic [W-1:0]              onehot
);
    localparam int unsigned IW = idx_width(W);

    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = int'(W) - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
        if (found) begin
            onehot[idx] = 1'b1;
        end
    end
endmodule

// File: rtl/vec_pic_req_latch.sv
`timescale 1ns/1ps
// Rising-edge request capture; a captured request is held until cleared
module vec_pic_req_latch #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lines,
    input  logic [W-1:0] clr,
    output logic [W-1:0] req
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] req;
    } lat_t;

    lat_t q, d;

    always_comb begin
        d      = q;
        d.prev = lines;
        // a fresh edge wins over a clear of the same bit
        d.req  = (q.req & ~clr) | (lines & ~q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req = q.req;
endmodule

// File: rtl/vec_pic.sv
`timescale 1ns/1ps
module vec_pic
    import vec_pic_pkg::*;
#(
    parameter int unsigned NUM_IRQ   = PIC_NUM_IRQ,
    parameter int unsigned FIRST_IRQ = PIC_FIRST_IRQ,
    parameter int unsigned VEC_BASE  = PIC_VEC_BASE,
    parameter int unsigned DATA_W    = PIC_DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               mask_wr,
    input  logic [DATA_W-1:0]  mask_wdata,
    output logic [DATA_W-1:0]  mask_rdata,
    input  logic               inta,
    input  logic               eoi,
    output logic               intr,
    output logic               vec_valid,
    output logic [DATA_W-1:0]  vec_data
);
    localparam int unsigned IW = idx_width(NUM_IRQ);
    localparam logic [DATA_W-1:0] VEC_LO   = DATA_W'(VEC_BASE + FIRST_IRQ);
    localparam logic [DATA_W-1:0] VEC_SPUR = DATA_W'(VEC_BASE + FIRST_IRQ + NUM_IRQ - 1);

    typedef struct packed {
        logic [DATA_W-1:0]  mask;
        logic [NUM_IRQ-1:0] isr;
        logic [DATA_W-1:0]  vec;
        logic               vec_valid;
    } pic_state_t;

    localparam pic_state_t RESET_STATE = '{
        mask:      '1,
        isr:       '0,
        vec:       '0,
        vec_valid: 1'b0
    };

    pic_state_t q, d;

    logic [NUM_IRQ-1:0] req_q;
    logic [NUM_IRQ-1:0] isr_q;
    logic [NUM_IRQ-1:0] line_mask;
    logic [NUM_IRQ-1:0] cand;
    logic               cand_found, isr_found;
    logic [IW-1:0]      cand_idx, isr_idx;
    logic [NUM_IRQ-1:0] cand_oh, isr_oh;
    logic               grant;
    logic [NUM_IRQ-1:0] grant_oh;

    assign isr_q     = q.isr;
    assign line_mask = q.mask[FIRST_IRQ +: NUM_IRQ];
    assign cand      = req_q & ~line_mask;

    vec_pic_req_latch #(.W(NUM_IRQ)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .lines (irq_lines),
        .clr   (grant_oh),
        .req   (req_q)
    );

    vec_pic_prio_find #(.W(NUM_IRQ)) u_cand (
        .vec    (cand),
        .found  (cand_found),
        .idx    (cand_idx),
        .onehot (cand_oh)
    );

    vec_pic_prio_find #(.W(NUM_IRQ)) u_isr (
        .vec    (isr_q),
        .found  (isr_found),
        .idx    (isr_idx),
        .onehot (isr_oh)
    );

    // Only a strictly higher priority (lower index) than the top in-service level may interrupt
    assign intr     = cand_found && (!isr_found || (cand_idx < isr_idx));
    assign grant    = inta && intr;
    assign grant_oh = grant ? cand_oh : '0;

    always_comb begin
        d = q;
        if (mask_wr) begin
            d.mask = mask_wdata;
        end
        d.isr = q.isr & ~(eoi ? isr_oh : '0);
        if (grant) begin
            d.isr = d.isr | cand_oh;
        end
        d.vec_valid = inta;
        if (inta) begin
            d.vec = grant ? (VEC_LO + DATA_W'(cand_idx)) : VEC_SPUR;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_STATE;
        end else begin
            q <= d;
        end
    end

    assign mask_rdata = q.mask;
    assign vec_valid  = q.vec_valid;
    assign vec_data   = q.vec;
endmodule

// File: rtl/vec_pic_chk.sv
`timescale 1ns/1ps
module vec_pic_chk #(
    parameter int unsigned NUM_IRQ = 6,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned VEC_LOW = 10,
    parameter int unsigned VEC_TOP = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DATA_W-1:0]  mask_rdata,
    input logic               inta,
    input logic               eoi,
    input logic               intr,
    input logic               vec_valid,
    input logic [DATA_W-1:0]  vec_data,
    input logic [NUM_IRQ-1:0] isr_q
);
    // R3: a fully masked controller never requests
    a_r3_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rdata == '1) |-> !intr);

    // R7: an acknowledge yields a type byte inside the legal range
    a_r7_vector_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && intr) |=> (vec_valid && vec_data >= DATA_W'(VEC_LOW) && vec_data <= DATA_W'(VEC_TOP)));

    // R7: the valid flag only follows an acknowledge
    a_r7_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(inta));

    // R7: a granted acknowledge adds exactly one in-service level
    a_r7_isr_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && intr && !eoi) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1));

    // R9: end-of-interrupt removes exactly one in-service level
    a_r9_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !inta && (isr_q != '0)) |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));

    // R10: a spurious acknowledge returns the top type and touches no level
    a_r10_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !intr && !eoi) |=> (vec_data == DATA_W'(VEC_TOP) && $stable(isr_q)));
endmodule

bind vec_pic vec_pic_chk #(
    .NUM_IRQ (NUM_IRQ),
    .DATA_W  (DATA_W),
    .VEC_LOW (VEC_BASE + FIRST_IRQ),
    .VEC_TOP (VEC_BASE + FIRST_IRQ + NUM_IRQ - 1)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_rdata (mask_rdata),
    .inta       (inta),
    .eoi        (eoi),
    .intr       (intr),
    .vec_valid  (vec_valid),
    .vec_data   (vec_data),
    .isr_q      (isr_q)
);

// File: tb/vec_pic_tb.sv
`timescale 1ns/1ps
module vec_pic_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] irq_lines = '0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [7:0] mask_rdata;
    logic       inta = 1'b0;
    logic       eoi = 1'b0;
    logic       intr;
    logic       vec_valid;
    logic [7:0] vec_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    vec_pic u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_lines  (irq_lines),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .mask_rdata (mask_rdata),
        .inta       (inta),
        .eoi        (eoi),
        .intr       (intr),
        .vec_valid  (vec_valid),
        .vec_data   (vec_data)
    );

    // {mask byte, line pattern (bit n = IRQn), expected intr, expected type}
    localparam int NV = 8;
    localparam logic [24:0] VEC_TBL [NV] = '{
        {8'h00, 8'h04, 1'b1, 8'd10},
        {8'h00, 8'h80, 1'b1, 8'd15},
        {8'h00, 8'hA8, 1'b1, 8'd11},
        {8'h08, 8'hA8, 1'b1, 8'd13},
        {8'hFF, 8'hFC, 1'b0, 8'd0},
        {8'h7F, 8'hFC, 1'b1, 8'd15},
        {8'h03, 8'h50, 1'b1, 8'd12},
        {8'hF3, 8'h30, 1'b0, 8'd0}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_lines = '0; inta = 1'b0; eoi = 1'b0; mask_wr = 1'b0;
        step(); step(); step();
        rst_n = 1'b1;
    endtask

    task automatic write_mask(input logic [7:0] b);
        mask_wr = 1'b1; mask_wdata = b;
        step();
        mask_wr = 1'b0;
    endtask

    task automatic pulse_irq(input int n);
        irq_lines[n-2] = 1'b1;
        step();
        irq_lines[n-2] = 1'b0;
    endtask

    task automatic ack();
        inta = 1'b1;
        step();
        inta = 1'b0;
    endtask

    task automatic send_eoi();
        eoi = 1'b1;
        step();
        eoi = 1'b0;
    endtask

    initial begin
        // table of patterns: R6 priority, R7 type byte, R3 masking
        for (int k = 0; k < NV; k++) begin
            do_reset();
            write_mask(VEC_TBL[k][24:17]);
            irq_lines = VEC_TBL[k][16:11];
            step();
            irq_lines = '0;
            chk("R6", $sformatf("intr vec%0d", k), {7'd0, intr}, {7'd0, VEC_TBL[k][8]});
            if (VEC_TBL[k][8]) begin
                ack();
                chk("R7", $sformatf("valid vec%0d", k), {7'd0, vec_valid}, 8'd1);
                chk("R7", $sformatf("type vec%0d", k), vec_data, VEC_TBL[k][7:0]);
            end
        end

        // R1 reset state
        do_reset();
        chk("R1", "mask after reset", mask_rdata, 8'hFF);
        chk("R1", "intr after reset", {7'd0, intr}, 8'd0);
        chk("R1", "valid after reset", {7'd0, vec_valid}, 8'd0);

        // R2 mask byte read/write
        write_mask(8'h55);
        chk("R2", "mask readback", mask_rdata, 8'h55);
        write_mask(8'h00);
        chk("R2", "mask readback zero", mask_rdata, 8'h00);

        // R3 masked request held, released by unmasking
        do_reset();
        pulse_irq(4);
        chk("R3", "masked intr", {7'd0, intr}, 8'd0);
        write_mask(8'hEF);
        chk("R3", "unmasked intr", {7'd0, intr}, 8'd1);
        ack();
        chk("R7", "type irq4", vec_data, 8'd12);
        step();
        chk("R7", "valid one cycle", {7'd0, vec_valid}, 8'd0);
        chk("R7", "intr after ack", {7'd0, intr}, 8'd0);

        // R5 latency and R4 edge sensitivity
        do_reset();
        write_mask(8'h00);
        irq_lines[3] = 1'b1;
        #0;
        chk("R5", "intr before edge", {7'd0, intr}, 8'd0);
        step();
        chk("R5", "intr after edge", {7'd0, intr}, 8'd1);
        ack();
        chk("R7", "type irq5", vec_data, 8'd13);
        send_eoi();
        step();
        chk("R4", "held level no rerequest", {7'd0, intr}, 8'd0);
        irq_lines[3] = 1'b0;
        step();
        chk("R4", "fall no request", {7'd0, intr}, 8'd0);
        pulse_irq(5);
        chk("R4", "new edge request", {7'd0, intr}, 8'd1);

        // R8 nesting and R11 re-request of in-service level
        do_reset();
        write_mask(8'h00);
        pulse_irq(4);
        ack();
        chk("R7", "type nest first", vec_data, 8'd12);
        pulse_irq(6);
        chk("R8", "lower prio blocked", {7'd0, intr}, 8'd0);
        pulse_irq(4);
        chk("R8", "equal prio blocked", {7'd0, intr}, 8'd0);
        pulse_irq(3);
        chk("R8", "higher prio nests", {7'd0, intr}, 8'd1);
        ack();
        chk("R8", "nested type", vec_data, 8'd11);
        send_eoi();
        chk("R9", "still blocked by irq4", {7'd0, intr}, 8'd0);
        send_eoi();
        chk("R11", "re-request raises", {7'd0, intr}, 8'd1);
        ack();
        chk("R11", "re-request type", vec_data, 8'd12);
        send_eoi();
        chk("R6", "irq6 left pending", {7'd0, intr}, 8'd1);
        ack();
        chk("R7", "type irq6", vec_data, 8'd14);
        send_eoi();
        chk("R9", "all drained", {7'd0, intr}, 8'd0);

        // R9 EOI clears the highest-priority level only
        do_reset();
        write_mask(8'h00);
        pulse_irq(5);
        ack();
        pulse_irq(2);
        ack();
        chk("R7", "type irq2", vec_data, 8'd10);
        pulse_irq(4);
        chk("R8", "irq4 under irq2", {7'd0, intr}, 8'd0);
        send_eoi();
        chk("R9", "eoi cleared irq2 not irq5", {7'd0, intr}, 8'd1);

        // R10 spurious acknowledge
        do_reset();
        write_mask(8'h00);
        ack();
        chk("R10", "spurious valid", {7'd0, vec_valid}, 8'd1);
        chk("R10", "spurious type", vec_data, 8'd15);
        pulse_irq(7);
        chk("R10", "no level set by spurious", {7'd0, intr}, 8'd1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule